// File: doc/BRIEF.md
# Shared-Port Fetch Sequencer

This block steers a two-stage pipeline in which instruction fetch and data access go through one memory port. It holds the program counter and the instruction register. Each cycle it decodes the opcode of the instruction in the register, which is the one executing. From that opcode it decides four things: which address drives the shared port, whether the program counter advances, where the next program counter comes from, and whether the instruction register takes the fetched word or a no-op.

A load or a store takes the port for its data access. The program counter holds for that cycle and a no-op enters the pipeline, so the following instruction is fetched again one cycle later from the same address. A jump, or a branch whose taken flag is set, redirects the program counter. The word fetched in that cycle is discarded and replaced by a no-op, because the pipeline has no delay slot. Memory accesses are strictly serialized and a write takes one cycle, so a store to an instruction location is seen by any later fetch without an extra interlock. The ALU, the register file and the memory sit outside the block. The block takes the ALU's data address, the branch outcome and the memory's read word as inputs.

Top module: `fctl_top`

## Requirements
- R1: While `rst_n` is low, `pc` equals `START_PC` (default 0) and `ir` holds the all-zero no-op word. The no-op's opcode 0 is of the ALU class.
- R2: When the executing opcode is a load or a store, `pc_en` is 0 and `pc` is unchanged after the next clock edge.
- R3: For a load or store, `addr_sel` is 1 and `mem_addr` equals `alu_addr`. For any other opcode, `addr_sel` is 0 and `mem_addr` equals `pc`.
- R4: For a load, a store, a jump or a taken branch, `ir_sel` is 1 and `ir` is the all-zero no-op after the next edge.
- R5: After a load or store, the word at the held `pc` enters `ir` one cycle after the no-op, which is two edges after the load or store was executing.
- R6: For a jump, `npc_sel` is 2 and the next `pc` is {`pc`[31:28], `ir`[25:0], 2'b00}. Here `pc` is the address that follows the jump.
- R7: For a branch with `br_taken` high, `npc_sel` is 1 and the next `pc` is `pc` + sign-extended `ir`[15:0] × 4. With `br_taken` low, a branch behaves as in R8.
- R8: For every other case, `pc_en` is 1, `npc_sel` is 0, `ir_sel` is 0, `pc` advances by 4 and `ir` takes `mem_rdata`.
- R9: The opcode is `ir`[31:26]. The value 0x23 is a load, 0x2B a store, 0x02 a jump and 0x04 a branch. Every other value, 0x09 for example, is of the ALU class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rdata | input | 32 | Word read from the shared memory port |
| alu_addr | input | 32 | Data address computed by the ALU |
| br_taken | input | 1 | Branch outcome for the executing branch |
| pc | output | 32 | Program counter, the next fetch address |
| ir | output | 32 | Executing instruction |
| mem_addr | output | 32 | Address driven onto the shared port |
| pc_en | output | 1 | Program counter update enable |
| addr_sel | output | 1 | Port address source: 0 = PC, 1 = ALU |
| npc_sel | output | 2 | Next PC source: 0 = +4, 1 = branch, 2 = jump |
| ir_sel | output | 1 | IR source: 0 = memory, 1 = no-op |

## Verification
The selects, `pc_en` and `mem_addr` are combinational functions of `ir`, so they are due in the same cycle as the instruction that causes them. `pc` and `ir` change one edge later, and the refetch after a load or store shows in `ir` two edges later. The bench advances a reference model at each falling edge and queues the expected values for the state now present. A monitor compares those values a moment after the same falling edge, well clear of the rising edge. Each compared field carries the tag of the instruction class that produced it.

// File: rtl/fctl_pkg.sv
package fctl_pkg;

  typedef enum logic [1:0] {
    NPC_SEQ = 2'd0,
    NPC_BR  = 2'd1,
    NPC_JMP = 2'd2
  } npc_sel_e;

  typedef struct packed {
    logic ld;
    logic st;
    logic jmp;
    logic br;
    logic alu;
  } op_class_t;

endpackage

// File: rtl/fctl_decode.sv
module fctl_decode
  import fctl_pkg::*;
#(
  parameter int          OPW       = 6,
  parameter logic [5:0]  OP_LOAD   = 6'h23,
  parameter logic [5:0]  OP_STORE  = 6'h2B,
  parameter logic [5:0]  OP_JUMP   = 6'h02,
  parameter logic [5:0]  OP_BRANCH = 6'h04
) (
  input  logic [OPW-1:0] opcode,
  output op_class_t      cls
);

  always_comb begin
    cls     = '0;
    cls.ld  = (opcode == OP_LOAD[OPW-1:0]);
    cls.st  = (opcode == OP_STORE[OPW-1:0]);
    cls.jmp = (opcode == OP_JUMP[OPW-1:0]);
    cls.br  = (opcode == OP_BRANCH[OPW-1:0]);
    cls.alu = !(cls.ld || cls.st || cls.jmp || cls.br);
  end

endmodule

// File: rtl/fctl_hazard.sv
module fctl_hazard
  import fctl_pkg::*;
(
  input  op_class_t cls,
  input  logic      br_taken,
  output logic      pc_en,
  output logic      addr_sel,
  output npc_sel_e  npc_sel,
  output logic      ir_sel
);

  logic port_steal;
  logic redirect_br;

  always_comb begin
    port_steal  = cls.ld || cls.st;
    redirect_br = cls.br && br_taken;
    pc_en       = !port_steal;
    addr_sel    = port_steal;
    if (cls.jmp)
      npc_sel = NPC_JMP;
    else if (redirect_br)
      npc_sel = NPC_BR;
    else
      npc_sel = NPC_SEQ;
    ir_sel = port_steal || cls.jmp || redirect_br;
  end

endmodule

// File: rtl/fctl_pc.sv
module fctl_pc
  import fctl_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          OPW      = 6,
  parameter int          IMMW     = 16,
  parameter logic [31:0] START_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_en,
  input  npc_sel_e          npc_sel,
  input  logic [XLEN-OPW-1:0] ir_field,
  output logic [XLEN-1:0]   pc
);

  localparam int JW   = XLEN - OPW;
  localparam int KEEP = XLEN - JW - 2;
  localparam int SEXW = XLEN - IMMW - 2;

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_d;
  logic [XLEN-1:0] jmp_tgt;
  logic [XLEN-1:0] br_tgt;

  always_comb begin
    jmp_tgt = {pc_q[XLEN-1 -: KEEP], ir_field, 2'b00};
    br_tgt  = pc_q + {{SEXW{ir_field[IMMW-1]}}, ir_field[IMMW-1:0], 2'b00};
    case (npc_sel)
      NPC_JMP: pc_d = jmp_tgt;
      NPC_BR:  pc_d = br_tgt;
      default: pc_d = pc_q + XLEN'(4);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pc_q <= START_PC[XLEN-1:0];
    else if (pc_en)
      pc_q <= pc_d;
  end

  assign pc = pc_q;

  a_r2_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_en |=> pc == $past(pc));

  a_r8_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_en && npc_sel == NPC_SEQ) |=> pc == $past(pc) + XLEN'(4));

  a_r6_jump_region: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_en && npc_sel == NPC_JMP) |=>
      (pc[1:0] == 2'b00 && pc[XLEN-1 -: KEEP] == $past(pc[XLEN-1 -: KEEP])));

endmodule

// File: rtl/fctl_ir.sv
module fctl_ir #(
  parameter int          XLEN     = 32,
  parameter logic [31:0] NOP_WORD = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ir_sel,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] ir
);

  logic [XLEN-1:0] ir_q;
  logic [XLEN-1:0] ir_d;

  always_comb begin
    ir_d = ir_sel ? NOP_WORD[XLEN-1:0] : mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ir_q <= NOP_WORD[XLEN-1:0];
    else
      ir_q <= ir_d;
  end

  assign ir = ir_q;

  a_r4_squash: assert property (@(posedge clk) disable iff (!rst_n)
    ir_sel |=> ir == NOP_WORD[XLEN-1:0]);

  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_sel |=> ir == $past(mem_rdata));

endmodule

// File: rtl/fctl_top.sv
module fctl_top
  import fctl_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          OPW       = 6,
  parameter int          IMMW      = 16,
  parameter logic [31:0] START_PC  = 32'h0,
  parameter logic [31:0] NOP_WORD  = 32'h0,
  parameter logic [5:0]  OP_LOAD   = 6'h23,
  parameter logic [5:0]  OP_STORE  = 6'h2B,
  parameter logic [5:0]  OP_JUMP   = 6'h02,
  parameter logic [5:0]  OP_BRANCH = 6'h04
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic [XLEN-1:0] alu_addr,
  input  logic            br_taken,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] ir,
  output logic [XLEN-1:0] mem_addr,
  output logic            pc_en,
  output logic            addr_sel,
  output logic [1:0]      npc_sel,
  output logic            ir_sel
);

  localparam int JW = XLEN - OPW;

  op_class_t cls;
  npc_sel_e  npc_sel_w;
  logic      pc_en_w;
  logic      addr_sel_w;
  logic      ir_sel_w;

  fctl_decode #(
    .OPW(OPW), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
    .OP_JUMP(OP_JUMP), .OP_BRANCH(OP_BRANCH)
  ) u_decode (
    .opcode (ir[XLEN-1 -: OPW]),
    .cls    (cls)
  );

  fctl_hazard u_hazard (
    .cls      (cls),
    .br_taken (br_taken),
    .pc_en    (pc_en_w),
    .addr_sel (addr_sel_w),
    .npc_sel  (npc_sel_w),
    .ir_sel   (ir_sel_w)
  );

  fctl_pc #(
    .XLEN(XLEN), .OPW(OPW), .IMMW(IMMW), .START_PC(START_PC)
  ) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc_en    (pc_en_w),
    .npc_sel  (npc_sel_w),
    .ir_field (ir[JW-1:0]),
    .pc       (pc)
  );

  fctl_ir #(
    .XLEN(XLEN), .NOP_WORD(NOP_WORD)
  ) u_ir (
    .clk       (clk),
    .rst_n     (rst_n),
    .ir_sel    (ir_sel_w),
    .mem_rdata (mem_rdata),
    .ir        (ir)
  );

  always_comb begin
    mem_addr = addr_sel_w ? alu_addr : pc;
  end

  assign pc_en    = pc_en_w;
  assign addr_sel = addr_sel_w;
  assign npc_sel  = npc_sel_w;
  assign ir_sel   = ir_sel_w;

  a_r9_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cls) == 1);

  a_r7_redirect_squash: assert property (@(posedge clk) disable iff (!rst_n)
    (npc_sel_w != NPC_SEQ) |-> ir_sel_w);

  a_r3_port_owner: assert property (@(posedge clk) disable iff (!rst_n)
    addr_sel_w |-> (!pc_en_w && ir_sel_w));

  a_r5_refetch: assert property (@(posedge clk) disable iff (!rst_n)
    addr_sel_w |=> (mem_addr == $past(pc)));

endmodule

// File: tb/fctl_top_tb_top.sv
module fctl_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] mem_rdata, alu_addr;
  logic        br_taken;
  logic [31:0] pc, ir, mem_addr;
  logic        pc_en, addr_sel, ir_sel;
  logic [1:0]  npc_sel;

  logic [31:0] mem [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  fctl_top dut_i (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .alu_addr(alu_addr),
    .br_taken(br_taken), .pc(pc), .ir(ir), .mem_addr(mem_addr),
    .pc_en(pc_en), .addr_sel(addr_sel), .npc_sel(npc_sel), .ir_sel(ir_sel)
  );

  // behavioural stubs for ALU, branch unit and memory
  assign alu_addr  = {16'h0, ir[15:0]};
  assign br_taken  = (ir[31:26] == 6'h04) && ir[25];
  assign mem_rdata = mem[mem_addr[7:2]];
  always @(posedge clk)
    if (rst_n && ir[31:26] == 6'h2B) mem[alu_addr[7:2]] <= 32'hCAFE_0001;

  typedef struct {
    logic [31:0] pc, ir, maddr;
    logic        pen, asel, isel;
    logic [1:0]  nsel;
    string       tpc, tir, tn;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;

  logic [31:0] m_pc, m_ir;
  string       last_pc_tag, last_ir_tag;
  logic        prev_ls, prev2_ls;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pc = 32'h0; m_ir = 32'h0;
    last_pc_tag = "R1"; last_ir_tag = "R1";
    prev_ls = 1'b0; prev2_ls = 1'b0;
  endtask

  // driver: compute expected outputs for present state, push, then advance
  task automatic step();
    exp_t e;
    logic [5:0] op;
    logic ld, st, jp, tk, ls;
    op = m_ir[31:26];
    ld = (op == 6'h23); st = (op == 6'h2B); jp = (op == 6'h02);
    tk = (op == 6'h04) && m_ir[25];
    ls = ld || st;
    e.pc = m_pc; e.ir = m_ir;
    e.pen = !ls; e.asel = ls; e.isel = ls || jp || tk;
    e.maddr = ls ? {16'h0, m_ir[15:0]} : m_pc;
    e.nsel = jp ? 2'd2 : (tk ? 2'd1 : 2'd0);
    e.tpc = last_pc_tag;
    e.tir = prev2_ls ? "R5" : last_ir_tag;
    e.tn = jp ? "R6" : (tk ? "R7" : "R8");
    q.push_back(e);
    if (ls) last_pc_tag = "R2";
    else if (jp) last_pc_tag = "R6";
    else if (op == 6'h04) last_pc_tag = "R7";
    else if (op != 6'h00) last_pc_tag = "R9";
    else last_pc_tag = "R8";
    last_ir_tag = e.isel ? "R4" : "R8";
    prev2_ls = prev_ls; prev_ls = ls;
    m_ir = e.isel ? 32'h0 : mem[m_pc[7:2]];
    if (ls) m_pc = m_pc;
    else if (jp) m_pc = {m_pc[31:28], m_ir_field(e.ir), 2'b00};
    else if (tk) m_pc = m_pc + {{14{e.ir[15]}}, e.ir[15:0], 2'b00};
    else m_pc = m_pc + 32'd4;
  endtask

  function automatic logic [25:0] m_ir_field(logic [31:0] w);
    return w[25:0];
  endfunction

  // monitor: pop and compare away from the rising edge
  always @(negedge clk) begin
    #2;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tpc, "pc", pc, e.pc);
      chk(e.tir, "ir", ir, e.ir);
      chk("R2", "pc_en", {31'h0, pc_en}, {31'h0, e.pen});
      chk("R3", "addr_sel", {31'h0, addr_sel}, {31'h0, e.asel});
      chk("R3", "mem_addr", mem_addr, e.maddr);
      chk("R4", "ir_sel", {31'h0, ir_sel}, {31'h0, e.isel});
      chk(e.tn, "npc_sel", {30'h0, npc_sel}, {30'h0, e.nsel});
    end
  end

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      step();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[0]  = 32'h0000_0011;
    mem[1]  = {6'h23, 10'h0, 16'h0080};
    mem[2]  = {6'h09, 26'h5};
    mem[3]  = {6'h2B, 10'h0, 16'h0084};
    mem[4]  = {6'h23, 10'h0, 16'h0088};
    mem[5]  = {6'h04, 1'b0, 9'h0, 16'h0005};
    mem[6]  = {6'h04, 1'b1, 9'h0, 16'h0003};
    mem[7]  = 32'h0000_0077;
    mem[10] = {6'h02, 26'd20};
    mem[17] = {6'h02, 26'd0};
    mem[20] = 32'h0000_0033;
    mem[21] = {6'h04, 1'b1, 9'h0, 16'hFFFB};
    mem[32] = 32'h1111_1111;
    mem[33] = 32'h2222_2222;
    mem[34] = 32'h3333_3333;

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "reset pc", pc, 32'h0);
    chk("R1", "reset ir", ir, 32'h0);
    model_reset();
    rst_n = 1'b1;
    step();
    run_cycles(45);

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "async reset pc", pc, 32'h0);
    chk("R1", "async reset ir", ir, 32'h0);
    @(negedge clk);
    model_reset();
    rst_n = 1'b1;
    step();
    run_cycles(25);

    @(negedge clk);
    #4;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule